// File: doc/BRIEF.md
# TDD Frame Timing Controller

This block generates the time-division-duplex control strobes for a radio front end. A frame counter steps through each frame, and six strobes are switched against it: RX VCO enable, TX VCO enable, RX RF enable, TX RF enable, RX data valid and TX data valid. Each strobe opens and closes at programmable counter values. Every strobe has a primary window and a secondary window, and the secondary window is switched in per strobe. A burst length sets how many frames run after an enable rising edge. A burst length of zero keeps frames running until enable falls.

The frame starts can be tied to an external pulse, such as a one-pulse-per-second reference. The pulse passes through a two-flop synchronizer and its rising edge is detected. That edge either releases a counter that is held waiting, or snaps a running counter back to frame start. A one-cycle sync output marks each frame start, so further units can follow this one. All configuration arrives as plain inputs, which are expected to be stable while the controller is stopped.

Top module: `tdd_frame_timer`

## Requirements
- R1: While reset is low, and after it is released with enable low, all six strobes and sync_out are low.
- R2: A frame counts from 0 up to frame_len inclusive, so it lasts frame_len+1 cycles. After frame_len the counter returns to 0.
- R3: When burst_len is N>0, exactly N frames run after an enable rising edge, and then every output stays low while enable remains high. When burst_len is 0, frames repeat without end.
- R4: When enable is low at a clock edge, the controller stops. All strobes and sync_out are low from the second edge after enable is seen low. A restart requires a new rising edge of enable.
- R5: A window goes high one cycle after the counter equals its on value. It goes low one cycle after the counter equals its off value. If on equals off, the on match wins. A window whose off value is below its on value wraps across the frame boundary.
- R6: Bit i of sec_en ORs the secondary window of strobe i into that strobe. Strobe index: 0 RX VCO, 1 TX VCO, 2 RX RF, 3 TX RF, 4 RX valid, 5 TX valid. Even indices are RX.
- R7: en_mode selects the enabled paths: 0 enables both RX and TX, 1 enables RX only and holds the TX strobes low, 2 enables TX only and holds the RX strobes low, and 3 behaves as 0.
- R8: gate_mode selects which data-valid strobes follow their windows: 0 both, 1 RX only, 2 TX only, 3 none. A valid strobe that is not gated stays high for every cycle the counter runs. It rises together with the first window update after starting, and is still subject to R7.
- R9: With sync_wait high at the enable edge, the counter holds at 0 with all strobes low. Counting starts when the synchronized rising edge of sync_in arrives. That edge is seen three clock edges after sync_in rises.
- R10: A synchronized sync_in rising edge while running sets the counter to 0 on that edge, which starts a new frame.
- R11: sync_out pulses high for one cycle, one cycle after each cycle in which the counter runs at value 0.
- R12: The first frame after an enable edge starts at cnt_init rather than 0. Later frames start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request; its rising edge starts a burst |
| en_mode | input | 2 | Path enable selection (R7) |
| gate_mode | input | 2 | Data-valid gating selection (R8) |
| sync_wait | input | 1 | Hold at frame start until a sync edge |
| sync_in | input | 1 | External alignment pulse, asynchronous |
| frame_len | input | CW | Last counter value of a frame |
| cnt_init | input | CW | Counter value of the first frame after enable |
| burst_len | input | BW | Frames per burst, 0 for unlimited |
| sec_en | input | 6 | Secondary window enable per strobe |
| on_pri | input | 6*CW | Primary on values, strobe i at bits i*CW |
| off_pri | input | 6*CW | Primary off values |
| on_sec | input | 6*CW | Secondary on values |
| off_sec | input | 6*CW | Secondary off values |
| rx_vco_en | output | 1 | RX oscillator enable |
| tx_vco_en | output | 1 | TX oscillator enable |
| rx_rf_en | output | 1 | RX RF path enable |
| tx_rf_en | output | 1 | TX RF path enable |
| rx_valid | output | 1 | RX data valid |
| tx_valid | output | 1 | TX data valid |
| sync_out | output | 1 | Frame-start pulse |

## Verification
A counter that has slipped moves every window edge and the sync_out pulse by the same amount. A per-cycle comparison therefore exposes it on the first window edge after the fault, and always by the next frame start. A burst counter that is off by one shows up as an extra frame or a missing frame at the end of the burst, and a stuck run state shows up as strobes that never drop after enable falls. A broken synchronizer or edge detector shifts the first frame after a sync pulse by one or more cycles, so it is seen within three cycles of the pulse.

// File: rtl/tdd_pkg.sv
package tdd_pkg;
  localparam int NUM_STROBES = 6;

  typedef enum logic {ST_OFF = 1'b0, ST_ON = 1'b1} tdd_state_t;

  localparam logic [1:0] SEL_BOTH = 2'd0;
  localparam logic [1:0] SEL_RX   = 2'd1;
  localparam logic [1:0] SEL_TX   = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;
endpackage

// File: rtl/tdd_sync_edge.sv
module tdd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic edge_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], pulse_in};
  end

  assign edge_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/tdd_frame_ctr.sv
module tdd_frame_ctr
  import tdd_pkg::*;
#(
  parameter int CW = 24,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          sync_wait,
  input  logic          sync_edge,
  input  logic [CW-1:0] frame_len,
  input  logic [CW-1:0] cnt_init,
  input  logic [BW-1:0] burst_len,
  output logic [CW-1:0] cnt_o,
  output logic          active_o
);
  tdd_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] burst_q, burst_d;
  logic          wait_q, wait_d;
  logic          en_q;
  logic          active, end_frame, end_burst;

  assign active    = (state_q == ST_ON) && !wait_q;
  assign end_frame = active && (cnt_q == frame_len);
  assign end_burst = end_frame && (burst_q == BW'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    burst_d = burst_q;
    wait_d  = wait_q;
    if (state_q == ST_OFF || !enable || end_burst) begin
      cnt_d   = cnt_init;
      burst_d = burst_len;
      wait_d  = sync_wait;
      if (state_q == ST_OFF) begin
        if (enable && !en_q) state_d = ST_ON;
      end else begin
        state_d = ST_OFF;
      end
    end else if (sync_edge) begin
      cnt_d  = '0;
      wait_d = 1'b0;
    end else if (wait_q) begin
      cnt_d = '0;
    end else if (end_frame) begin
      cnt_d = '0;
      if (burst_q != '0) burst_d = burst_q - 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      burst_q <= '0;
      wait_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      burst_q <= burst_d;
      wait_q  <= wait_d;
      en_q    <= enable;
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = active;

  // R2: a running frame wraps to 0 after its last count
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && !wait_q && enable && !sync_edge && cnt_q == frame_len && burst_q != BW'(1))
    |=> (cnt_q == '0));

  // R3: the last frame of a finite burst stops the controller
  a_r3_burst_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && !wait_q && enable && cnt_q == frame_len && burst_q == BW'(1))
    |=> (state_q == ST_OFF));

  // R9: while waiting for sync the counter stays at frame start
  a_r9_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && wait_q && enable && !sync_edge) |=> (cnt_q == '0 && state_q == ST_ON));
endmodule

// File: rtl/tdd_window.sv
module tdd_window #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] on_pri,
  input  logic [CW-1:0] off_pri,
  input  logic [CW-1:0] on_sec,
  input  logic [CW-1:0] off_sec,
  input  logic          sec_en,
  output logic          win_o
);
  logic pri_q, pri_d, sec_q, sec_d;

  always_comb begin
    pri_d = pri_q;
    sec_d = sec_q;
    if (!active) begin
      pri_d = 1'b0;
      sec_d = 1'b0;
    end else begin
      if (cnt == on_pri)       pri_d = 1'b1;
      else if (cnt == off_pri) pri_d = 1'b0;
      if (cnt == on_sec)       sec_d = 1'b1;
      else if (cnt == off_sec) sec_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      pri_q <= pri_d;
      sec_q <= sec_d;
    end
  end

  assign win_o = pri_q | (sec_en & sec_q);

  // R5: an on match opens the primary window on the next cycle
  a_r5_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == on_pri) |=> pri_q);
endmodule

// File: rtl/tdd_frame_timer.sv
module tdd_frame_timer
  import tdd_pkg::*;
#(
  parameter int CW = 24,
  parameter int BW = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [1:0]                en_mode,
  input  logic [1:0]                gate_mode,
  input  logic                      sync_wait,
  input  logic                      sync_in,
  input  logic [CW-1:0]             frame_len,
  input  logic [CW-1:0]             cnt_init,
  input  logic [BW-1:0]             burst_len,
  input  logic [NUM_STROBES-1:0]    sec_en,
  input  logic [NUM_STROBES*CW-1:0] on_pri,
  input  logic [NUM_STROBES*CW-1:0] off_pri,
  input  logic [NUM_STROBES*CW-1:0] on_sec,
  input  logic [NUM_STROBES*CW-1:0] off_sec,
  output logic                      rx_vco_en,
  output logic                      tx_vco_en,
  output logic                      rx_rf_en,
  output logic                      tx_rf_en,
  output logic                      rx_valid,
  output logic                      tx_valid,
  output logic                      sync_out
);
  logic                   sync_edge, active;
  logic [CW-1:0]          cnt;
  logic                   active_q, sync_out_q;
  logic [NUM_STROBES-1:0] win, strobe;
  logic                   path_rx, path_tx, gate_rx, gate_tx;

  tdd_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pulse_in(sync_in), .edge_o(sync_edge)
  );

  tdd_frame_ctr #(.CW(CW), .BW(BW)) i_ctr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_wait(sync_wait),
    .sync_edge(sync_edge), .frame_len(frame_len), .cnt_init(cnt_init),
    .burst_len(burst_len), .cnt_o(cnt), .active_o(active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      sync_out_q <= 1'b0;
    end else begin
      active_q   <= active;
      sync_out_q <= active && (cnt == '0);
    end
  end

  assign path_rx = (en_mode != SEL_TX);
  assign path_tx = (en_mode != SEL_RX);
  assign gate_rx = (gate_mode == SEL_BOTH) || (gate_mode == SEL_RX);
  assign gate_tx = (gate_mode == SEL_BOTH) || (gate_mode == SEL_TX);

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
    localparam bit IS_RX = (g % 2) == 0;
    localparam bit IS_DV = g >= 4;
    logic raw;

    tdd_window #(.CW(CW)) i_win (
      .clk(clk), .rst_n(rst_n), .active(active), .cnt(cnt),
      .on_pri(on_pri[g*CW +: CW]), .off_pri(off_pri[g*CW +: CW]),
      .on_sec(on_sec[g*CW +: CW]), .off_sec(off_sec[g*CW +: CW]),
      .sec_en(sec_en[g]), .win_o(win[g])
    );

    if (IS_DV) begin : g_dv
      assign raw = (IS_RX ? gate_rx : gate_tx) ? win[g] : active_q;
    end else begin : g_ctl
      assign raw = win[g];
    end
    assign strobe[g] = raw & (IS_RX ? path_rx : path_tx);
  end

  assign rx_vco_en = strobe[0];
  assign tx_vco_en = strobe[1];
  assign rx_rf_en  = strobe[2];
  assign tx_rf_en  = strobe[3];
  assign rx_valid  = strobe[4];
  assign tx_valid  = strobe[5];
  assign sync_out  = sync_out_q;

  // R4: two edges with enable low leave every output low on the next cycle
  a_r4_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && $past(!enable)) |=> (strobe == '0 && !sync_out));
endmodule

// File: tb/test_tdd_frame_timer.sv
module test_tdd_frame_timer;
  localparam int CW = 24;
  localparam int BW = 6;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] en_mode = 2'd0;
  logic [1:0] gate_mode = 2'd0;
  logic sync_wait = 1'b0;
  logic sync_in = 1'b0;
  logic [CW-1:0] frame_len = '0;
  logic [CW-1:0] cnt_init = '0;
  logic [BW-1:0] burst_len = '0;
  logic [NS-1:0] sec_en = '0;
  logic [CW-1:0] c_on_p [NS];
  logic [CW-1:0] c_off_p[NS];
  logic [CW-1:0] c_on_s [NS];
  logic [CW-1:0] c_off_s[NS];
  logic [NS*CW-1:0] on_pri, off_pri, on_sec, off_sec;
  logic rx_vco_en, tx_vco_en, rx_rf_en, tx_rf_en, rx_valid, tx_valid, sync_out;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      on_pri[i*CW +: CW]  = c_on_p[i];
      off_pri[i*CW +: CW] = c_off_p[i];
      on_sec[i*CW +: CW]  = c_on_s[i];
      off_sec[i*CW +: CW] = c_off_s[i];
    end
  end

  tdd_frame_timer #(.CW(CW), .BW(BW)) i_tdd_frame_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .en_mode(en_mode),
    .gate_mode(gate_mode), .sync_wait(sync_wait), .sync_in(sync_in),
    .frame_len(frame_len), .cnt_init(cnt_init), .burst_len(burst_len),
    .sec_en(sec_en), .on_pri(on_pri), .off_pri(off_pri), .on_sec(on_sec),
    .off_sec(off_sec), .rx_vco_en(rx_vco_en), .tx_vco_en(tx_vco_en),
    .rx_rf_en(rx_rf_en), .tx_rf_en(tx_rf_en), .rx_valid(rx_valid),
    .tx_valid(tx_valid), .sync_out(sync_out)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_on = 0, m_wt = 0, m_enq = 0, m_actq = 0, m_soq = 0;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0;
  bit m_wp[NS], m_ws[NS];
  int m_cnt = 0, m_bl = 0;

  initial for (int i = 0; i < NS; i++) begin m_wp[i] = 0; m_ws[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_wt = 0; m_enq = 0; m_actq = 0; m_soq = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_bl = 0;
      for (int i = 0; i < NS; i++) begin m_wp[i] = 0; m_ws[i] = 0; end
    end else begin
      bit act, edge_seen, last_frame;
      act = m_on && !m_wt;
      for (int i = 0; i < NS; i++) begin
        if (!act) begin m_wp[i] = 0; m_ws[i] = 0; end
        else begin
          if (m_cnt == int'(c_on_p[i])) m_wp[i] = 1;
          else if (m_cnt == int'(c_off_p[i])) m_wp[i] = 0;
          if (m_cnt == int'(c_on_s[i])) m_ws[i] = 1;
          else if (m_cnt == int'(c_off_s[i])) m_ws[i] = 0;
        end
      end
      m_soq = act && (m_cnt == 0);
      m_actq = act;
      edge_seen = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
      last_frame = act && (m_cnt == int'(frame_len)) && (m_bl == 1);
      if (!m_on || !enable || last_frame) begin
        if (!m_on) m_on = enable && !m_enq;
        else m_on = 0;
        m_cnt = int'(cnt_init); m_bl = int'(burst_len); m_wt = sync_wait;
      end else if (edge_seen) begin
        m_cnt = 0; m_wt = 0;
      end else if (m_wt) begin
        m_cnt = 0;
      end else if (m_cnt == int'(frame_len)) begin
        m_cnt = 0;
        if (m_bl != 0) m_bl--;
      end else begin
        m_cnt++;
      end
      m_enq = enable;
    end
  end

  function automatic logic [NS-1:0] expected();
    logic [NS-1:0] e;
    for (int i = 0; i < NS; i++) begin
      bit w, rx, path, gated;
      rx = (i % 2) == 0;
      w = m_wp[i] | (sec_en[i] & m_ws[i]);
      path = rx ? (en_mode != 2'd2) : (en_mode != 2'd1);
      gated = rx ? (gate_mode == 2'd0 || gate_mode == 2'd1)
                 : (gate_mode == 2'd0 || gate_mode == 2'd2);
      if (i >= 4 && !gated) w = m_actq;
      e[i] = w & path;
    end
    return e;
  endfunction

  function automatic logic [NS-1:0] dut_vec();
    return {tx_valid, rx_valid, tx_rf_en, rx_rf_en, tx_vco_en, rx_vco_en};
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [NS-1:0] e, a;
      e = expected();
      a = dut_vec();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s strobes t=%0t actual=%b expected=%b", cur_req, $time, a, e);
      end
      checks++;
      if (sync_out !== m_soq) begin
        errors++;
        $display("FAIL R11 sync_out t=%0t actual=%b expected=%b", $time, sync_out, m_soq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic stop_run();
    enable = 1'b0;
    step(3);
  endtask

  task automatic check_quiet(string req);
    checks++;
    if (dut_vec() !== '0 || sync_out !== 1'b0) begin
      errors++;
      $display("FAIL %s quiet actual=%b/%b expected=000000/0", req, dut_vec(), sync_out);
    end
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin
      c_on_p[i] = CW'(i + 1); c_off_p[i] = CW'(i + 4);
      c_on_s[i] = CW'(7);     c_off_s[i] = CW'(9);
    end
    step(5);
    check_quiet("R1");
    rst_n = 1'b1;
    step(3);
    check_quiet("R1");

    // R2: free-running frames of length 10
    cur_req = "R2"; frame_len = CW'(9);
    enable = 1'b1; step(35); stop_run();

    // R3: two-frame burst, enable held high afterwards
    cur_req = "R3"; burst_len = BW'(2);
    enable = 1'b1; step(30);
    check_quiet("R3");
    stop_run();

    // R4: disable mid-frame with unlimited burst
    cur_req = "R4"; burst_len = '0;
    enable = 1'b1; step(15);
    enable = 1'b0; step(2);
    check_quiet("R4");
    step(2);

    // R5: wrapping windows and equal on/off
    cur_req = "R5";
    for (int i = 0; i < NS; i++) begin c_on_p[i] = CW'(6); c_off_p[i] = CW'(2); end
    c_on_p[1] = CW'(3); c_off_p[1] = CW'(3);
    enable = 1'b1; step(25); stop_run();

    // R6: secondary windows on alternate strobes
    cur_req = "R6";
    for (int i = 0; i < NS; i++) begin c_on_p[i] = CW'(1); c_off_p[i] = CW'(3); end
    sec_en = 6'b010101;
    enable = 1'b1; step(25); stop_run();

    // R7: single-path modes
    cur_req = "R7";
    en_mode = 2'd1; enable = 1'b1; step(15); stop_run();
    en_mode = 2'd2; enable = 1'b1; step(15); stop_run();
    en_mode = 2'd0;

    // R8: data-valid gating choices
    cur_req = "R8";
    for (int g = 1; g < 4; g++) begin
      gate_mode = 2'(g); enable = 1'b1; step(15); stop_run();
    end
    gate_mode = 2'd0;

    // R12: first frame starts at the initial value
    cur_req = "R12"; cnt_init = CW'(5); burst_len = BW'(2);
    enable = 1'b1; step(25); stop_run();
    cnt_init = '0; burst_len = '0;

    // R9: wait for an external sync edge
    cur_req = "R9"; sync_wait = 1'b1;
    enable = 1'b1; step(10);
    check_quiet("R9");
    sync_in = 1'b1; step(2); sync_in = 1'b0;
    step(20); stop_run();
    sync_wait = 1'b0;

    // R10: realign a running frame
    cur_req = "R10";
    enable = 1'b1; step(14);
    sync_in = 1'b1; step(1); sync_in = 1'b0;
    step(20); stop_run();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule